// File: doc/BRIEF.md
# Write Streaming Mode Detector

This block watches the store traffic a core sends towards its caches and decides, separately for each cache level, when write misses should stop allocating lines. It counts runs of cacheable writes that each cover a whole cache line, where each write targets the line directly after the one before it. When a level's run reaches the threshold programmed for that level, the block raises that level's streaming flag. The cache controller reads the flag. While it is set, a write that misses is passed on to the next level and no line fill is started. Loads are not affected by the flag.

Levels are chained. The first level sees every cacheable whole-line write. Each deeper level only counts the writes that arrive while the level above it is already streaming, which are the writes being forwarded past that level. Streaming ends on two events:
- a cacheable write that covers only part of a line;
- a load whose line falls inside the run of lines that the current stream has written.

Either event clears every level.

Addresses are line indices, so one step of the index is one 64-byte line. Both event ports use valid/ready. Ready is tied high: the block only observes traffic, so it never applies back-pressure. An event counts in every cycle in which valid is high.

Top module: `wsm_detector`

## Requirements
- R1: After reset every streaming flag is low, every run count is zero and no run is active.
- R2: Level 1 adds one to its run count for each cacheable full-line write whose line index is one more than the previous such write. Its flag rises in the cycle after the write that brings the count equal to its threshold.
- R3: A cacheable full-line write that does not follow on from the previous line starts a new run with count 1. An already raised flag stays high.
- R4: A write with the cacheable bit low does not change any count, run or flag.
- R5: A cacheable write with the full-line bit low clears all counts, runs and flags at the next clock edge.
- R6: A load whose line lies between the first and the last line of level 1's current run (inclusive) clears all counts, runs and flags. A load outside that range has no effect.
- R7: Level 2 counts only full-line writes that arrive while level 1's flag is high. Level 3 counts only those that arrive while level 2's flag is high. Each uses its own threshold with the rules of R2 and R3.
- R8: A configuration write (cfg_sel 0, 1 or 2 selects level 1, 2 or 3) loads that level's threshold and clears its count and flag. A threshold of 0 keeps the level from ever streaming. Counts saturate at the threshold.
- R9: wr_ready and ld_ready are always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Write event present |
| wr_ready | output | 1 | Always 1 |
| wr_line | input | AW | Line index of the write |
| wr_full | input | 1 | Write covers the whole line |
| wr_cacheable | input | 1 | Write targets cacheable memory |
| ld_valid | input | 1 | Load event present |
| ld_ready | output | 1 | Always 1 |
| ld_line | input | AW | Line index of the load |
| cfg_we | input | 1 | Threshold register write |
| cfg_sel | input | SW | Level selected for the threshold write |
| cfg_value | input | TW | New threshold value |
| stream_o | output | LEVELS | Per-level streaming flag, bit 0 is level 1 |

## Verification
The directed tests cover several write patterns:
- A clean ascending run, which shows that the flag rises exactly on the threshold-th write.
- A run broken by a jump, which shows a restart apart from a continuation.
- Interleaved non-cacheable and partial writes, which show that the first is ignored while the second ends the stream.
- Loads just inside and just outside the run, which exercise the inclusive range check.

Continuing a run past level 1's threshold shows that the deeper levels count only forwarded writes. A threshold of 0 shows that a level can be disabled. Random traffic then mixes mostly-sequential streams with jumps, partial writes, loads and threshold rewrites. This traffic is compared cycle by cycle against a model written from the requirements.

// File: rtl/wsm_pkg.sv
package wsm_pkg;
  localparam int WSM_LEVELS   = 3;
  localparam int WSM_LINE_AW  = 32;
  localparam int WSM_THR_W    = 4;
  localparam int WSM_THR_INIT = 4;

  typedef enum logic [1:0] {
    LVL_NEAR = 2'd0,
    LVL_MID  = 2'd1,
    LVL_FAR  = 2'd2
  } wsm_level_e;
endpackage

// File: rtl/wsm_thresh_regs.sv
module wsm_thresh_regs #(
  parameter int LEVELS = 3,
  parameter int TW     = 4,
  parameter int INIT   = 4,
  localparam int SW    = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [SW-1:0]              cfg_sel,
  input  logic [TW-1:0]              cfg_value,
  output logic [LEVELS-1:0][TW-1:0]  thr_o,
  output logic [LEVELS-1:0]          clr_o
);
  for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
    assign clr_o[k] = cfg_we && (cfg_sel == SW'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        thr_o[k] <= TW'(INIT);
      else if (clr_o[k]) thr_o[k] <= cfg_value;
    end
  end
endmodule

// File: rtl/wsm_region_match.sv
module wsm_region_match #(
  parameter int AW = 32
) (
  input  logic          ld_valid,
  input  logic [AW-1:0] ld_line,
  input  logic          run_valid,
  input  logic [AW-1:0] run_start,
  input  logic [AW-1:0] run_last,
  output logic          hit
);
  logic [AW-1:0] off, span;
  // Modular offsets keep a run that wraps the index space contiguous.
  assign off  = ld_line - run_start;
  assign span = run_last - run_start;
  assign hit  = ld_valid && run_valid && (off <= span);
endmodule

// File: rtl/wsm_run_tracker.sv
module wsm_run_tracker #(
  parameter int AW = 32,
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] thr,
  input  logic          clr,
  input  logic          kill,
  input  logic          ev,
  input  logic [AW-1:0] ev_line,
  output logic          run_valid,
  output logic [AW-1:0] run_start,
  output logic [AW-1:0] run_last,
  output logic          stream
);
  logic [TW-1:0] cnt, cnt_next;
  logic          consec;

  assign consec = run_valid && (ev_line == run_last + AW'(1));

  always_comb begin
    if (thr == '0)          cnt_next = '0;
    else if (!consec)       cnt_next = TW'(1);
    else if (cnt >= thr)    cnt_next = thr;
    else                    cnt_next = cnt + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      run_valid <= 1'b0;
      run_start <= '0;
      run_last  <= '0;
      stream    <= 1'b0;
    end else if (clr || kill) begin
      cnt       <= '0;
      run_valid <= 1'b0;
      stream    <= 1'b0;
    end else if (ev) begin
      cnt       <= cnt_next;
      run_valid <= 1'b1;
      run_last  <= ev_line;
      if (!consec) run_start <= ev_line;
      if (thr != '0 && cnt_next == thr) stream <= 1'b1;
    end
  end

  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= thr); // R8
  AST_ZERO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (thr == '0) |-> !stream); // R8
  AST_EXIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !stream); // R5
  AST_SET_AT_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stream) |-> ($past(ev) && cnt == thr)); // R2
endmodule

// File: rtl/wsm_detector.sv
module wsm_detector
  import wsm_pkg::*;
#(
  parameter int LEVELS = WSM_LEVELS,
  parameter int AW     = WSM_LINE_AW,
  parameter int TW     = WSM_THR_W,
  parameter int INIT   = WSM_THR_INIT,
  localparam int SW    = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [AW-1:0]     wr_line,
  input  logic              wr_full,
  input  logic              wr_cacheable,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [AW-1:0]     ld_line,
  input  logic              cfg_we,
  input  logic [SW-1:0]     cfg_sel,
  input  logic [TW-1:0]     cfg_value,
  output logic [LEVELS-1:0] stream_o
);
  logic [LEVELS-1:0][TW-1:0] thr;
  logic [LEVELS-1:0]         clr;
  logic [LEVELS-1:0]         run_valid;
  logic [LEVELS-1:0][AW-1:0] run_start, run_last;
  logic [LEVELS-1:0]         lvl_ev;
  logic                      full_ev, partial_ev, ld_hit, kill;

  assign wr_ready   = 1'b1;
  assign ld_ready   = 1'b1;
  assign full_ev    = wr_valid && wr_cacheable && wr_full;
  assign partial_ev = wr_valid && wr_cacheable && !wr_full;
  assign kill       = partial_ev || ld_hit;

  wsm_thresh_regs #(.LEVELS(LEVELS), .TW(TW), .INIT(INIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_value(cfg_value), .thr_o(thr), .clr_o(clr)
  );

  wsm_region_match #(.AW(AW)) u_match (
    .ld_valid(ld_valid), .ld_line(ld_line), .run_valid(run_valid[0]),
    .run_start(run_start[0]), .run_last(run_last[0]), .hit(ld_hit)
  );

  for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
    if (k == 0) begin : g_head
      assign lvl_ev[k] = full_ev;
    end else begin : g_chain
      // Deeper level sees only writes forwarded past a streaming level.
      assign lvl_ev[k] = full_ev && stream_o[k-1];
      AST_FWD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stream_o[k]) |-> $past(stream_o[k-1])); // R7
    end
    wsm_run_tracker #(.AW(AW), .TW(TW)) u_trk (
      .clk(clk), .rst_n(rst_n), .thr(thr[k]), .clr(clr[k]), .kill(kill),
      .ev(lvl_ev[k]), .ev_line(wr_line), .run_valid(run_valid[k]),
      .run_start(run_start[k]), .run_last(run_last[k]), .stream(stream_o[k])
    );
  end

  AST_LOAD_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    ld_hit |=> (stream_o == '0)); // R6
  AST_NONCACHE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_cacheable && !ld_hit && !cfg_we) |=> $stable(stream_o)); // R4
endmodule

// File: tb/wsm_detector_test.sv
module wsm_detector_test;
  localparam int L = 3;
  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, wr_full = 0, wr_cacheable = 0, ld_valid = 0, cfg_we = 0;
  logic [31:0] wr_line = 0, ld_line = 0;
  logic [1:0] cfg_sel = 0;
  logic [3:0] cfg_value = 0;
  logic wr_ready, ld_ready;
  logic [L-1:0] stream_o;
  int checks = 0, errors = 0;
  bit done = 0;

  // Model state
  int unsigned m_cnt[L], m_thr[L];
  logic [31:0] m_start[L], m_last[L];
  bit m_val[L], m_str[L];

  always #2.5 clk = ~clk;

  wsm_detector uut (.clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_line(wr_line), .wr_full(wr_full), .wr_cacheable(wr_cacheable),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_line(ld_line), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_value(cfg_value), .stream_o(stream_o));

  function automatic bit in_run(logic [31:0] a);
    return m_val[0] && ((a - m_start[0]) <= (m_last[0] - m_start[0]));
  endfunction

  function automatic logic [L-1:0] model_flags();
    logic [L-1:0] f;
    for (int k = 0; k < L; k++) f[k] = m_str[k];
    return f;
  endfunction

  task automatic model_step();
    bit old_str[L];
    bit ev0, kill, ev, consec;
    int unsigned inc;
    for (int k = 0; k < L; k++) old_str[k] = m_str[k];
    ev0  = wr_valid && wr_cacheable && wr_full;
    kill = (wr_valid && wr_cacheable && !wr_full) || (ld_valid && in_run(ld_line));
    for (int k = 0; k < L; k++) begin
      ev = ev0 && (k == 0 || old_str[k-1]);
      if ((cfg_we && cfg_sel == k) || kill) begin
        m_cnt[k] = 0; m_val[k] = 0; m_str[k] = 0;
      end else if (ev) begin
        consec = m_val[k] && (wr_line == m_last[k] + 1);
        if (m_thr[k] == 0) inc = 0;
        else if (!consec) inc = 1;
        else inc = (m_cnt[k] >= m_thr[k]) ? m_thr[k] : m_cnt[k] + 1;
        m_cnt[k] = inc;
        if (!consec) m_start[k] = wr_line;
        m_last[k] = wr_line; m_val[k] = 1;
        if (m_thr[k] != 0 && inc == m_thr[k]) m_str[k] = 1;
      end
    end
    if (cfg_we && cfg_sel < L) m_thr[cfg_sel] = cfg_value;
  endtask

  task automatic check(string req, logic [L-1:0] act, logic [L-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // One cycle: inputs already driven at negedge; advance and sample at next negedge.
  task automatic cyc(string req);
    @(posedge clk);
    model_step();
    @(negedge clk);
    wr_valid = 0; ld_valid = 0; cfg_we = 0;
    check(req, stream_o, model_flags());
  endtask

  task automatic wr(logic [31:0] a, bit full, bit cach, string req);
    wr_valid = 1; wr_line = a; wr_full = full; wr_cacheable = cach;
    cyc(req);
  endtask

  task automatic ld(logic [31:0] a, string req);
    ld_valid = 1; ld_line = a;
    cyc(req);
  endtask

  task automatic cfg(int s, int v);
    cfg_we = 1; cfg_sel = 2'(s); cfg_value = 4'(v);
    cyc("R8");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    if (!done) begin
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < L; k++) begin
      m_cnt[k] = 0; m_thr[k] = 4; m_val[k] = 0; m_str[k] = 0; m_start[k] = 0; m_last[k] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", stream_o, '0);
    checks++; if (!(wr_ready && ld_ready)) begin errors++; $display("FAIL R9 actual=%b%b expected=11", wr_ready, ld_ready); end

    cfg(0, 3); cfg(1, 2); cfg(2, 2);
    wr(100, 1, 1, "R2"); wr(101, 1, 1, "R2");
    check("R2", stream_o, 3'b000);
    wr(102, 1, 1, "R2");
    check("R2", stream_o, 3'b001);
    wr(103, 1, 1, "R7"); check("R7", stream_o, 3'b001);
    wr(104, 1, 1, "R7"); check("R7", stream_o, 3'b011);
    wr(999, 0, 0, "R4"); check("R4", stream_o, 3'b011);
    wr(105, 1, 1, "R7"); wr(106, 1, 1, "R7"); check("R7", stream_o, 3'b111);
    ld(99, "R6");  check("R6", stream_o, 3'b111);
    ld(107, "R6"); check("R6", stream_o, 3'b111);
    ld(100, "R6"); check("R6", stream_o, 3'b000);
    wr(10, 1, 1, "R5"); wr(11, 1, 1, "R5"); wr(12, 1, 1, "R5");
    check("R5", stream_o, 3'b001);
    wr(13, 0, 1, "R5"); check("R5", stream_o, 3'b000);
    wr(200, 1, 1, "R3"); wr(201, 1, 1, "R3"); wr(500, 1, 1, "R3"); wr(501, 1, 1, "R3");
    check("R3", stream_o, 3'b000);
    wr(502, 1, 1, "R3"); check("R3", stream_o, 3'b001);
    wr(900, 1, 1, "R3"); check("R3", stream_o, 3'b001);
    cfg(0, 0);
    check("R8", stream_o, 3'b000);
    for (int i = 0; i < 8; i++) wr(32'(300 + i), 1, 1, "R8");
    check("R8", stream_o, 3'b000);
    cfg(0, 2);
    for (int i = 0; i < 12; i++) wr(32'(700 + i), 1, 1, "R8");
    check("R8", stream_o, 3'b111);

    // Constrained random traffic
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 70) begin
        wr_valid = 1; wr_full = 1; wr_cacheable = 1;
        wr_line = ($urandom_range(0, 9) == 0) ? 32'($urandom_range(0, 4000)) : wr_line + 1;
      end else if (r < 76) begin
        wr_valid = 1; wr_full = 1'($urandom); wr_cacheable = 0; wr_line = 32'($urandom);
      end else if (r < 79) begin
        wr_valid = 1; wr_full = 0; wr_cacheable = 1; wr_line = 32'($urandom_range(0, 4000));
      end else if (r < 86) begin
        ld_valid = 1; ld_line = wr_line - 32'($urandom_range(0, 40));
      end else if (r < 88) begin
        cfg_we = 1; cfg_sel = 2'($urandom_range(0, 2)); cfg_value = 4'($urandom_range(0, 6));
      end
      if (r >= 70 && r < 79 && $urandom_range(0, 3) == 0) begin
        ld_valid = 1; ld_line = 32'($urandom_range(0, 4000));
      end
      cyc("R2/R7 random");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule